// File: doc/BRIEF.md
# Reorder Buffer with Precise Exceptions

This block is a circular window of eight in-flight instructions. Instructions enter at the tail in program order, and each one is given the index of the slot it occupies. Execution units later report completion against that index, in any order. A report carries a result value and a fault flag. Results stay inside the buffer until their slot reaches the head. They reach architectural state only through the retire lanes, strictly oldest first, at most two per cycle.

When the oldest entry is complete and marked faulting, it is not retired. The controller moves from state ST_RUN to state ST_FLUSH, which lasts exactly one cycle. During that cycle the block raises a flush pulse and presents the faulting slot's index and instruction address as the restart point. The block then discards that entry and every younger one, including entries whose results are already complete, and returns to ST_RUN with an empty buffer.

Transitions: ST_RUN to ST_FLUSH when a complete, faulting entry is the first non-retirable slot seen from the head (fault_found). ST_FLUSH to ST_RUN unconditionally after one cycle. ST_RUN to ST_RUN otherwise.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: alloc_ready_o is 1, ret_valid_o is 0, flush_o is 0 and alloc_idx_o is 0.
- R2: Each accepted allocation (alloc_req_i high while alloc_ready_o is high) takes the slot shown on alloc_idx_o, and the next slot index is one higher, modulo 8.
- R3: Once 8 entries are held and none has retired, alloc_ready_o is 0. A request made in that state is not taken, so the tail does not move.
- R4: A completion report naming a slot that holds no entry is ignored. A later allocation of that slot starts incomplete.
- R5: An incomplete entry at the head blocks all retirement, even when younger entries are complete. Retirement never happens while the buffer is empty.
- R6: Up to 2 entries retire per cycle. Lane 0 (bits [DW-1:0] of ret_data_o) carries the older entry, and lane 1 is valid only when lane 0 is valid. Retirement stops at the first incomplete or faulting entry.
- R7: A complete, faulting entry is never retired. In the cycle after it is found, flush_o is high for exactly one cycle, exc_idx_o holds its slot index and exc_pc_o holds its instruction address.
- R8: On a flush, all entries younger than the faulting one are discarded, complete or not, and never appear on the retire lanes. Afterwards the buffer is empty and alloc_idx_o equals the faulting slot's index.
- R9: Entries older than the faulting one retire normally, including in the same cycle in which the fault is found on lane 1.
- R10: During the flush cycle alloc_ready_o is 0 and no lane retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_req_i | input | 1 | Request to insert an instruction at the tail |
| alloc_pc_i | input | PCW | Instruction address of the new entry |
| alloc_dest_i | input | RW | Destination register of the new entry |
| alloc_ready_o | output | 1 | Tail slot can be taken this cycle |
| alloc_idx_o | output | IW | Slot index given to the next allocation |
| cmp_valid_i | input | 1 | Completion report present |
| cmp_idx_i | input | IW | Slot index the report applies to |
| cmp_data_i | input | DW | Result value |
| cmp_fault_i | input | 1 | Report marks the instruction as faulting |
| ret_valid_o | output | CW | Per-lane retire strobe, lane 0 oldest |
| ret_dest_o | output | CW*RW | Per-lane destination register |
| ret_data_o | output | CW*DW | Per-lane result value |
| flush_o | output | 1 | One-cycle squash pulse |
| exc_idx_o | output | IW | Faulting slot index, valid with flush_o |
| exc_pc_o | output | PCW | Restart address, valid with flush_o |

## Verification
The checker keeps its own occupancy count from accepted allocations, retirements and flushes. It assumes that the buffer accepts allocations only while alloc_ready_o is high and that the pointers wrap modulo a power-of-two depth. It also assumes that completion reports name slots already handed out, or else slots that are empty. The directed stimulus raises alloc_req_i only after observing alloc_ready_o, except in the one deliberate full-buffer probe. It sends at most one report per slot, except the one deliberate report to an empty slot.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } rob_state_e;
endpackage

// File: rtl/rob_slot_array.sv
module rob_slot_array #(
    parameter int DEPTH = 8,
    parameter int IW    = 3,
    parameter int PCW   = 16,
    parameter int RW    = 5,
    parameter int DW    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_new,
    input  logic [IW-1:0]              wr_idx,
    input  logic [PCW-1:0]             wr_pc,
    input  logic [RW-1:0]              wr_dest,
    input  logic                       res_we,
    input  logic [IW-1:0]              res_idx,
    input  logic [DW-1:0]              res_data,
    input  logic                       res_fault,
    input  logic [DEPTH-1:0]           drop_mask,
    output logic [DEPTH-1:0]           live_q,
    output logic [DEPTH-1:0]           done_q,
    output logic [DEPTH-1:0]           bad_q,
    output logic [DEPTH-1:0][PCW-1:0]  pc_q,
    output logic [DEPTH-1:0][RW-1:0]   dest_q,
    output logic [DEPTH-1:0][DW-1:0]   data_q
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_q[i] <= 1'b0;
                done_q[i] <= 1'b0;
                bad_q[i]  <= 1'b0;
                pc_q[i]   <= '0;
                dest_q[i] <= '0;
                data_q[i] <= '0;
            end else begin
                if (drop_mask[i]) begin
                    live_q[i] <= 1'b0;
                end else if (wr_new && wr_idx == IW'(i)) begin
                    live_q[i] <= 1'b1;
                    done_q[i] <= 1'b0;
                    bad_q[i]  <= 1'b0;
                    pc_q[i]   <= wr_pc;
                    dest_q[i] <= wr_dest;
                end
                if (res_we && res_idx == IW'(i)) begin
                    done_q[i] <= 1'b1;
                    bad_q[i]  <= res_fault;
                    data_q[i] <= res_data;
                end
            end
        end
    end
endmodule

// File: rtl/rob_retire_pick.sv
module rob_retire_pick #(
    parameter int DEPTH = 8,
    parameter int CW    = 2,
    parameter int IW    = 3
) (
    input  logic [IW-1:0]    head,
    input  logic [DEPTH-1:0] live,
    input  logic [DEPTH-1:0] done,
    input  logic [DEPTH-1:0] bad,
    output logic [CW-1:0]    take,
    output logic             fault_found
);
    logic [CW-1:0] hit_bad;
    logic [CW:0]   chain;

    assign chain[0] = 1'b1;

    for (genvar k = 0; k < CW; k++) begin : g_lane
        logic [IW-1:0] pos;
        assign pos        = head + IW'(k);
        assign take[k]    = chain[k] & live[pos] & done[pos] & ~bad[pos];
        assign hit_bad[k] = chain[k] & live[pos] & done[pos] & bad[pos];
        assign chain[k+1] = take[k];
    end

    assign fault_found = |hit_bad;
endmodule

// File: rtl/rob_core.sv
module rob_core #(
    parameter int DEPTH = 8,
    parameter int CW    = 2,
    parameter int PCW   = 16,
    parameter int RW    = 5,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int NW   = $clog2(CW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req_i,
    input  logic [PCW-1:0]    alloc_pc_i,
    input  logic [RW-1:0]     alloc_dest_i,
    output logic              alloc_ready_o,
    output logic [IW-1:0]     alloc_idx_o,
    input  logic              cmp_valid_i,
    input  logic [IW-1:0]     cmp_idx_i,
    input  logic [DW-1:0]     cmp_data_i,
    input  logic              cmp_fault_i,
    output logic [CW-1:0]     ret_valid_o,
    output logic [CW*RW-1:0]  ret_dest_o,
    output logic [CW*DW-1:0]  ret_data_o,
    output logic              flush_o,
    output logic [IW-1:0]     exc_idx_o,
    output logic [PCW-1:0]    exc_pc_o
);
    import rob_pkg::*;

    rob_state_e state_q, state_d;
    logic [IW-1:0] head_q, tail_q;
    logic          full_q;

    logic [DEPTH-1:0]          live, done, bad, drop_mask;
    logic [DEPTH-1:0][PCW-1:0] pc_q;
    logic [DEPTH-1:0][RW-1:0]  dest_q;
    logic [DEPTH-1:0][DW-1:0]  data_q;
    logic [CW-1:0]             take;
    logic                      fault_found;
    logic                      alloc_fire, res_fire;
    logic [NW-1:0]             n_ret;

    rob_slot_array #(.DEPTH(DEPTH), .IW(IW), .PCW(PCW), .RW(RW), .DW(DW)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_new    (alloc_fire),
        .wr_idx    (tail_q),
        .wr_pc     (alloc_pc_i),
        .wr_dest   (alloc_dest_i),
        .res_we    (res_fire),
        .res_idx   (cmp_idx_i),
        .res_data  (cmp_data_i),
        .res_fault (cmp_fault_i),
        .drop_mask (drop_mask),
        .live_q    (live),
        .done_q    (done),
        .bad_q     (bad),
        .pc_q      (pc_q),
        .dest_q    (dest_q),
        .data_q    (data_q)
    );

    rob_retire_pick #(.DEPTH(DEPTH), .CW(CW), .IW(IW)) u_pick (
        .head        (head_q),
        .live        (live),
        .done        (done),
        .bad         (bad),
        .take        (take),
        .fault_found (fault_found)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (fault_found) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // outputs and per-cycle controls
    always_comb begin
        flush_o       = (state_q == ST_FLUSH);
        alloc_ready_o = (state_q == ST_RUN) && !full_q;
        alloc_idx_o   = tail_q;
        alloc_fire    = alloc_req_i && alloc_ready_o;
        res_fire      = cmp_valid_i && (state_q == ST_RUN) && live[cmp_idx_i];
        ret_valid_o   = (state_q == ST_RUN) ? take : '0;
        exc_idx_o     = flush_o ? head_q : '0;
        exc_pc_o      = flush_o ? pc_q[head_q] : '0;
        n_ret         = '0;
        drop_mask     = flush_o ? '1 : '0;
        for (int k = 0; k < CW; k++) begin
            logic [IW-1:0] pos;
            pos = head_q + IW'(k);
            ret_dest_o[k*RW +: RW] = dest_q[pos];
            ret_data_o[k*DW +: DW] = data_q[pos];
            if (ret_valid_o[k]) begin
                n_ret          = n_ret + NW'(1);
                drop_mask[pos] = 1'b1;
            end
        end
    end

    // pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            full_q <= 1'b0;
        end else if (state_q == ST_FLUSH) begin
            tail_q <= head_q;
            full_q <= 1'b0;
        end else begin
            head_q <= head_q + IW'(n_ret);
            tail_q <= tail_q + IW'(alloc_fire);
            if (n_ret != '0)
                full_q <= 1'b0;
            else if (alloc_fire)
                full_q <= ((tail_q + IW'(1)) == head_q);
        end
    end
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 2,
    localparam int OW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_req_i,
    input logic          alloc_ready_o,
    input logic [CW-1:0] ret_valid_o,
    input logic          flush_o
);
    logic [OW-1:0] occ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       occ <= '0;
        else if (flush_o) occ <= '0;
        else              occ <= occ + OW'(alloc_req_i && alloc_ready_o)
                                     - OW'($countones(ret_valid_o));
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OW'(DEPTH)) |-> !alloc_ready_o);

    p_empty_no_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> (ret_valid_o == '0));

    // lanes form a prefix: lane k valid only if all older lanes valid
    p_lane_prefix_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ret_valid_o & (ret_valid_o + CW'(1))) == '0));

    p_flush_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    p_squash_young_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> (ret_valid_o == '0));

    p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (!alloc_ready_o && ret_valid_o == '0));
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .CW(CW)) u_rob_core_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_req_i   (alloc_req_i),
    .alloc_ready_o (alloc_ready_o),
    .ret_valid_o   (ret_valid_o),
    .flush_o       (flush_o)
);

// File: tb/rob_core_bench.sv
module rob_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16, RW = 5, PCW = 16, CW = 2, IW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_req_i = 0, cmp_valid_i = 0, cmp_fault_i = 0;
    logic [PCW-1:0] alloc_pc_i = '0;
    logic [RW-1:0]  alloc_dest_i = '0;
    logic [IW-1:0]  cmp_idx_i = '0;
    logic [DW-1:0]  cmp_data_i = '0;
    logic alloc_ready_o, flush_o;
    logic [IW-1:0] alloc_idx_o, exc_idx_o;
    logic [PCW-1:0] exc_pc_o;
    logic [CW-1:0] ret_valid_o;
    logic [CW*RW-1:0] ret_dest_o;
    logic [CW*DW-1:0] ret_data_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_core u_rob_core (.*);

    int total = 0, bad = 0;
    logic [DW-1:0] rlog [0:63];
    int rn = 0, pairs = 0, flushes = 0;
    logic [IW-1:0] last_exc_idx;
    logic [PCW-1:0] last_exc_pc;
    logic flush_ready_seen = 0, flush_ret_seen = 0;

    // retirement and flush monitor, mid-cycle
    always @(negedge clk) if (rst_n) begin
        if (ret_valid_o[0]) begin rlog[rn] = ret_data_o[DW-1:0]; rn++; end
        if (ret_valid_o[1]) begin rlog[rn] = ret_data_o[2*DW-1:DW]; rn++; end
        if (ret_valid_o == 2'b11) pairs++;
        if (flush_o) begin
            flushes++;
            last_exc_idx = exc_idx_o;
            last_exc_pc  = exc_pc_o;
            if (alloc_ready_o) flush_ready_seen = 1;
            if (ret_valid_o != 0) flush_ret_seen = 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic alloc(input logic [PCW-1:0] pc, output logic [IW-1:0] idx);
        idx = alloc_idx_o;
        alloc_req_i = 1; alloc_pc_i = pc; alloc_dest_i = RW'(pc);
        tick();
        alloc_req_i = 0;
    endtask

    task automatic complete(input logic [IW-1:0] idx, input logic [DW-1:0] d,
                            input logic f);
        cmp_valid_i = 1; cmp_idx_i = idx; cmp_data_i = d; cmp_fault_i = f;
        tick();
        cmp_valid_i = 0; cmp_fault_i = 0;
    endtask

    task automatic t_reset();
        chk(alloc_ready_o == 1, "R1", "ready", alloc_ready_o, 1);
        chk(ret_valid_o == 0, "R1", "ret_valid", ret_valid_o, 0);
        chk(flush_o == 0, "R1", "flush", flush_o, 0);
        chk(alloc_idx_o == 0, "R1", "alloc_idx", alloc_idx_o, 0);
    endtask

    task automatic t_order();
        logic [IW-1:0] a, b, c;
        int r0;
        alloc(16'h100, a); alloc(16'h104, b); alloc(16'h108, c);
        chk(a == 0 && b == 1 && c == 2, "R2", "idx seq", {a, b, c}, 'o012);
        r0 = rn;
        complete(c, 16'hC0, 0); complete(b, 16'hB0, 0);
        tick(3);
        chk(rn == r0, "R5", "head blocks", rn, r0);
        complete(a, 16'hA0, 0);
        tick(3);
        chk(rn == r0 + 3, "R5", "retired count", rn, r0 + 3);
        chk(rlog[r0] == 16'hA0 && rlog[r0+1] == 16'hB0 && rlog[r0+2] == 16'hC0,
            "R6", "order", rlog[r0+1], 16'hB0);
        chk(pairs >= 1, "R6", "dual retire", pairs, 1);
    endtask

    task automatic t_full();
        logic [IW-1:0] ids [8];
        logic [IW-1:0] start, dummy;
        int r0;
        start = alloc_idx_o;
        for (int i = 0; i < 8; i++) alloc(PCW'(16'h200 + 4*i), ids[i]);
        chk(alloc_ready_o == 0, "R3", "ready when full", alloc_ready_o, 0);
        alloc_req_i = 1; tick(); alloc_req_i = 0;
        r0 = rn;
        for (int i = 0; i < 8; i++) complete(ids[i], DW'(16'h50 + i), 0);
        tick(4);
        chk(rn == r0 + 8, "R3", "drained", rn, r0 + 8);
        chk(alloc_idx_o == start, "R3", "tail unmoved by refused req",
            alloc_idx_o, start);
        chk(rlog[r0+7] == 16'h57, "R6", "last of wrap", rlog[r0+7], 16'h57);
        dummy = 0;
    endtask

    task automatic t_ignore();
        logic [IW-1:0] k, got;
        int r0;
        k = alloc_idx_o;
        complete(k, 16'hDEAD, 0);
        r0 = rn;
        alloc(16'h300, got);
        tick(3);
        chk(rn == r0, "R4", "stale report ignored", rn, r0);
        complete(got, 16'h3A, 0);
        tick(2);
        chk(rn == r0 + 1 && rlog[r0] == 16'h3A, "R4", "real data", rlog[r0], 16'h3A);
    endtask

    task automatic t_fault_head();
        logic [IW-1:0] a, b, c, d, e;
        int r0, f0;
        r0 = rn; f0 = flushes;
        alloc(16'h400, a); alloc(16'h404, b); alloc(16'h408, c);
        alloc(16'h40C, d); alloc(16'h410, e);
        complete(e, 16'hE1, 0); complete(d, 16'hD1, 0);
        complete(c, 16'hC1, 1); complete(b, 16'hB1, 0);
        complete(a, 16'hA1, 0);
        tick(6);
        chk(rn == r0 + 2, "R9", "older retired", rn, r0 + 2);
        chk(rlog[r0] == 16'hA1 && rlog[r0+1] == 16'hB1, "R9", "older data",
            rlog[r0+1], 16'hB1);
        chk(flushes == f0 + 1, "R7", "one-cycle flush", flushes - f0, 1);
        chk(last_exc_idx == c, "R7", "exc idx", last_exc_idx, c);
        chk(last_exc_pc == 16'h408, "R7", "exc pc", last_exc_pc, 16'h408);
        chk(alloc_idx_o == c, "R8", "tail at fault", alloc_idx_o, c);
        chk(alloc_ready_o == 1, "R8", "empty after flush", alloc_ready_o, 1);
        tick(3);
        chk(rn == r0 + 2, "R8", "young never retire", rn, r0 + 2);
    endtask

    task automatic t_fault_lane1();
        logic [IW-1:0] f, g;
        int r0, f0;
        r0 = rn; f0 = flushes;
        alloc(16'h500, f); alloc(16'h504, g);
        complete(g, 16'h61, 1);
        complete(f, 16'h51, 0);
        tick(5);
        chk(rn == r0 + 1 && rlog[r0] == 16'h51, "R9", "lane0 before fault",
            rn - r0, 1);
        chk(flushes == f0 + 1 && last_exc_idx == g, "R7", "exc idx lane1",
            last_exc_idx, g);
        chk(last_exc_pc == 16'h504, "R7", "exc pc lane1", last_exc_pc, 16'h504);
        chk(alloc_idx_o == g, "R8", "tail at fault lane1", alloc_idx_o, g);
        chk(!flush_ready_seen, "R10", "ready during flush", flush_ready_seen, 0);
        chk(!flush_ret_seen, "R10", "retire during flush", flush_ret_seen, 0);
    endtask

    bit done_run = 0;
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        t_reset();
        t_order();
        t_full();
        t_ignore();
        t_fault_head();
        t_fault_lane1();
        done_run = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_run) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule